// File: doc/BRIEF.md
# Half-Bridge Gate Interlock with Dead Time

This block is the digital control for one leg of a three-phase inverter. Four inputs arrive from outside the clock domain: a high-side command, a low-side command, an active-low stop input and a supply-good flag. The supply-good flag already carries the undervoltage hysteresis. The block produces the two gate enables for the leg. It never lets both switches conduct together. It also keeps a switch off until the opposite switch has been off for a programmable number of clock cycles.

All four inputs pass through a two-stage synchronizer. The synchronized inputs are decoded into a requested leg state: off, low side on, or high side on. A dead-time sequencer then moves the registered leg state toward that request. It turns a conducting switch off at once. Before any turn-on it waits until the same request has been held for `DEAD_CYC` cycles with both switches off. As a fast path, the stop input and the supply-good flag also gate both outputs combinationally, so a fault removes gate drive in the same cycle it appears.

Top module: `hb_gate_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, gate_hi and gate_lo are both 0.
- R2: While shdn_n is 0, gate_hi and gate_lo are both 0 in that same cycle, whatever the commands are.
- R3: While supply_ok is 0, gate_hi and gate_lo are both 0 in that same cycle, whatever the commands are.
- R4: With cmd_hi=1 and cmd_lo=1, both gates are 0 from the third rising edge after the inputs change, and they stay 0 for as long as the commands are held.
- R5: With cmd_hi=0 and cmd_lo=0, both gates are 0 from the third rising edge after the inputs change.
- R6: cmd_lo=1 with cmd_hi=0 drives only gate_lo high. cmd_hi=1 with cmd_lo=0 drives only gate_hi high.
- R7: A gate turns on on the (DEAD_CYC+4)-th rising edge after its command is first sampled, and not earlier. The opposite gate is then already low for at least DEAD_CYC sampled cycles.
- R8: A conducting gate whose command is withdrawn goes low on the third rising edge after the change.
- R9: If the request changes while the dead time is still running, the count starts again: the new side turns on DEAD_CYC+4 edges after the latest change, and the side that was abandoned never turns on.
- R10: gate_hi and gate_lo are never 1 at the same time.
- R11: After shdn_n or supply_ok returns to 1 with a command held, the commanded gate turns on only after the full dead time, on the (DEAD_CYC+4)-th edge after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_hi | input | 1 | High-side command, active high, asynchronous |
| cmd_lo | input | 1 | Low-side command, active high, asynchronous |
| shdn_n | input | 1 | Stop input, active low, asynchronous |
| supply_ok | input | 1 | Supply above undervoltage threshold, hysteresis already applied |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |

## Verification
Four properties are checked on every cycle: the two gates are never high together, stop and supply-fail remove drive at once, the registered leg never jumps straight from one side to the other, and every turn-on is preceded by the opposite gate being low for at least the dead time. Only the directed scenarios can show the exact latencies: turn-on after DEAD_CYC+4 edges, turn-off after three edges, and the restart of the count when the request changes mid-window. The same holds for the decoding of each row of the command truth table and for the full dead time after a fault is released.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;
    typedef enum logic [1:0] {
        LEG_OFF  = 2'd0,
        LEG_LOW  = 2'd1,
        LEG_HIGH = 2'd2
    } leg_e;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/hb_decode.sv
module hb_decode
    import hb_gate_pkg::*;
(
    input  logic want_hi,
    input  logic want_lo,
    input  logic enable,
    output leg_e req
);
    always_comb begin
        if (!enable) begin
            req = LEG_OFF;
        end else begin
            unique case ({want_hi, want_lo})
                2'b10:   req = LEG_HIGH;
                2'b01:   req = LEG_LOW;
                default: req = LEG_OFF;   // 00 idle, 11 interlock
            endcase
        end
    end
endmodule

// File: rtl/hb_deadtime.sv
module hb_deadtime
    import hb_gate_pkg::*;
#(
    parameter int unsigned DEAD_CYC = 23,
    localparam int unsigned CNT_W   = (DEAD_CYC < 1) ? 1 : $clog2(DEAD_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  leg_e req,
    output leg_e leg
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEAD_CYC);

    typedef struct packed {
        leg_e             out;
        leg_e             prev;
        logic [CNT_W-1:0] cnt;
    } dt_state_t;

    dt_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = req;
        // idle counter: restarts on any request change or while conducting
        if (st_q.out != LEG_OFF || req != st_q.prev) begin
            st_d.cnt = '0;
        end else if (st_q.cnt < CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        // leg state
        if (st_q.out != LEG_OFF) begin
            if (req != st_q.out) st_d.out = LEG_OFF;
        end else if (req != LEG_OFF && req == st_q.prev && st_q.cnt == CNT_MAX) begin
            st_d.out = req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{out: LEG_OFF, prev: LEG_OFF, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign leg = st_q.out;

    // R7: the leg must pass through off between sides
    a_r7_no_hi_to_lo: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.out == LEG_HIGH |=> st_q.out != LEG_LOW);
    a_r7_no_lo_to_hi: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.out == LEG_LOW |=> st_q.out != LEG_HIGH);
    // R8: a withdrawn request drops the leg on the next edge
    a_r8_prompt_off: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.out != LEG_OFF && req != st_q.out) |=> st_q.out == LEG_OFF);
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
    import hb_gate_pkg::*;
#(
    parameter int unsigned DEAD_CYC    = 23,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned CNT_W      = (DEAD_CYC < 1) ? 1 : $clog2(DEAD_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_hi,
    input  logic cmd_lo,
    input  logic shdn_n,
    input  logic supply_ok,
    output logic gate_hi,
    output logic gate_lo
);
    localparam int unsigned NIN = 4;

    logic [NIN-1:0] in_sync;
    leg_e           req;
    leg_e           leg;
    logic           fast_en;

    hb_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({shdn_n, supply_ok, cmd_hi, cmd_lo}),
        .sync_o  (in_sync)
    );

    hb_decode u_decode (
        .want_hi (in_sync[1]),
        .want_lo (in_sync[0]),
        .enable  (in_sync[3] & in_sync[2]),
        .req     (req)
    );

    hb_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dead (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .leg   (leg)
    );

    // fast fault path bypasses the synchronizer
    assign fast_en = shdn_n & supply_ok;
    assign gate_hi = fast_en & (leg == LEG_HIGH);
    assign gate_lo = fast_en & (leg == LEG_LOW);

    // checker: cycles each gate has been low, saturating at the dead time
    localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(DEAD_CYC);
    logic [CNT_W-1:0] hi_low_run_q, lo_low_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_low_run_q <= '0;
            lo_low_run_q <= '0;
        end else begin
            if (gate_hi) hi_low_run_q <= '0;
            else if (hi_low_run_q < RUN_MAX) hi_low_run_q <= hi_low_run_q + 1'b1;
            if (gate_lo) lo_low_run_q <= '0;
            else if (lo_low_run_q < RUN_MAX) lo_low_run_q <= lo_low_run_q + 1'b1;
        end
    end

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo));
    a_r2_stop_kills: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |-> (!gate_hi && !gate_lo));
    a_r3_supply_kills: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |-> (!gate_hi && !gate_lo));
    a_r7_hi_dead: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi) |-> lo_low_run_q == RUN_MAX);
    a_r7_lo_dead: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_lo) |-> hi_low_run_q == RUN_MAX);
endmodule

// File: tb/hb_gate_ctrl_tb.sv
module hb_gate_ctrl_tb;
    localparam int D = 23;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_hi = 1'b0, cmd_lo = 1'b0, shdn_n = 1'b1, supply_ok = 1'b1;
    logic gate_hi, gate_lo;
    int   n_run = 0, n_fail = 0, n_both = 0;

    always #4 clk = ~clk;

    hb_gate_ctrl #(.DEAD_CYC(D)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
        .shdn_n(shdn_n), .supply_ok(supply_ok), .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    // R10 monitor
    always @(negedge clk) if (rst_n && gate_hi && gate_lo) n_both++;

    task automatic chk(string tag, logic [1:0] exp);
        n_run++;
        if ({gate_hi, gate_lo} !== exp) begin
            n_fail++;
            $display("FAIL %s: {hi,lo} actual %b expected %b at %0t", tag, {gate_hi, gate_lo}, exp, $time);
        end
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cmd(logic h, logic l);
        cmd_hi = h; cmd_lo = l;
    endtask

    task automatic idle_settle();
        cmd(1'b0, 1'b0); shdn_n = 1'b1; supply_ok = 1'b1;
        edges(D + 8);
    endtask

    task automatic t_reset();
        edges(3);
        chk("R1 in reset", 2'b00);
        rst_n = 1'b1;
        edges(1);
        chk("R1 after reset", 2'b00);
        edges(D + 8);
    endtask

    task automatic t_low_on();
        cmd(1'b0, 1'b1);
        edges(D + 3);
        chk("R7 low side not before dead time", 2'b00);
        edges(1);
        chk("R6 low side only", 2'b01);
    endtask

    task automatic t_low_to_high();
        cmd(1'b1, 1'b0);
        edges(2);
        chk("R8 low still on two edges after change", 2'b01);
        edges(1);
        chk("R8 low off on third edge", 2'b00);
        edges(D);
        chk("R7 high not before dead time", 2'b00);
        edges(1);
        chk("R6 high side only", 2'b10);
    endtask

    task automatic t_idle_cmd();
        cmd(1'b0, 1'b0);
        edges(3);
        chk("R5 both commands low", 2'b00);
        edges(D + 8);
        chk("R5 stays off", 2'b00);
    endtask

    task automatic t_both();
        cmd(1'b1, 1'b1);
        edges(3);
        chk("R4 both commands high", 2'b00);
        edges(D + 20);
        chk("R4 held interlock stays off", 2'b00);
        idle_settle();
    endtask

    task automatic t_restart();
        cmd(1'b1, 1'b0);
        edges(10);
        chk("R9 high pending", 2'b00);
        cmd(1'b0, 1'b1);
        edges(D + 3);
        chk("R9 restarted count not done", 2'b00);
        edges(1);
        chk("R9 new side on after full count", 2'b01);
        idle_settle();
    endtask

    task automatic t_stop();
        cmd(1'b1, 1'b0);
        edges(D + 4);
        chk("R6 high on before stop", 2'b10);
        shdn_n = 1'b0;
        #1;
        chk("R2 stop kills same cycle", 2'b00);
        cmd(1'b1, 1'b1);
        edges(2);
        chk("R2 stop with both commands", 2'b00);
        cmd(1'b0, 1'b1);
        edges(5);
        chk("R2 stop with low command", 2'b00);
        shdn_n = 1'b1;
        edges(D + 3);
        chk("R11 no turn-on before dead time after stop", 2'b00);
        edges(1);
        chk("R11 turn-on after stop release", 2'b01);
    endtask

    task automatic t_supply();
        supply_ok = 1'b0;
        #1;
        chk("R3 supply fail kills same cycle", 2'b00);
        cmd(1'b1, 1'b0);
        edges(6);
        chk("R3 supply fail with high command", 2'b00);
        supply_ok = 1'b1;
        edges(D + 3);
        chk("R11 no turn-on before dead time after supply", 2'b00);
        edges(1);
        chk("R11 turn-on after supply recovers", 2'b10);
        idle_settle();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_low_on();
        t_low_to_high();
        t_idle_cmd();
        t_both();
        t_restart();
        t_stop();
        t_supply();
        n_run++;
        if (n_both != 0) begin
            n_fail++;
            $display("FAIL R10: cycles with both gates high actual %0d expected 0", n_both);
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run not finished actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule